// File: doc/BRIEF.md
# Banked Interrupt Aggregator

The aggregator gathers level-sensitive interrupt requests into several identical banks of 32 sources. Every bank keeps a latched pending word, an enable word and a derived view of the pending sources that are enabled. A bank with at least one enabled pending source raises its own line toward the processor. Software reaches every bank through one flat 32-bit register bus. Banks repeat at a fixed address stride, and each bank has five word registers at fixed offsets.

A handler finds the bank from the line that fired and reads the enabled-pending view. It services the highest-numbered set bit first. The block supplies that bit index for each bank as an output, so software does not have to scan the word. Pending bits are cleared by writing ones to them. Software can also raise a source itself through a separate set register.

Top module: `irqc_top`

## Requirements
- R1: While reset is high, every pending bit and every enable bit is cleared on the clock edge. After reset, all processor lines are low, every bank's valid flag is low, and every register reads zero except the mask view, which reads all ones.
- R2: A request input that is high at a clock edge sets its pending bit at that edge. The bit stays set after the request falls, until software clears it. The pending word of bank n reads at address n*0x28 + 0x00.
- R3: Writing the pending word clears each bit written as 1 and leaves each bit written as 0 unchanged. A request that is high in the same cycle as the clear wins, so that bit stays set. Writing all ones clears the whole bank.
- R4: The enable word, at offset 0x08, reads back what was last written to it. The mask view, at offset 0x20, reads as the bitwise inverse of the enable word. A write to the mask view sets the enable word to the inverse of the written data.
- R5: The enabled-pending view, at offset 0x10, reads pending AND enable. Writes to this offset change nothing.
- R6: Writing the set register, at offset 0x18, sets every pending bit written as 1. This register always reads zero.
- R7: Only the five word offsets inside each bank are mapped. Other offsets, such as 0x04, and every address at or above NUM_BANKS*0x28 read zero. Writes to them change nothing.
- R8: Processor line n+2 is high exactly one cycle after the enabled-pending view of bank n is non-zero. Lines 0 and 1 are always low.
- R9: In the same cycle as the enabled-pending view, top_valid[n] is high when the view of bank n is non-zero. top_idx bits [5n+4:5n] carry the index of the view's most significant set bit, or zero when the view is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; bus_wdata is taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | input | 160 | Level requests; bank n uses bits [32n+31:32n] |
| cpu_irq | output | 7 | Registered processor lines; bank n drives bit n+2 |
| top_idx | output | 25 | Highest enabled pending index, 5 bits per bank |
| top_valid | output | 5 | Bank has an enabled pending source |

## Verification
Some properties are checked on every cycle. Each processor line must follow its bank's valid flag with a one-cycle delay. The index must be zero whenever a bank is idle. Unmapped addresses and the set register must read zero. Reset must leave all lines and flags low.

Other behaviour can only be shown by the bench scenarios. These cover the interplay of clears with requests still held high, inverted mask writes, writes ignored at the view offset, and the index chosen among many set bits. The bench drives random requests and bus traffic against its own register model to reach them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W      = 32;
    localparam int SRC_W       = DATA_W;
    localparam int IDX_W       = $clog2(SRC_W);
    localparam int BANK_STRIDE = 40;

    // word offsets inside one bank
    localparam int OFF_PEND  = 0;
    localparam int OFF_EN    = 8;
    localparam int OFF_GATED = 16;
    localparam int OFF_SET   = 24;
    localparam int OFF_MASK  = 32;

    typedef enum logic [2:0] {
        SEL_PEND,
        SEL_EN,
        SEL_GATED,
        SEL_SET,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] clr;
        logic [SRC_W-1:0] set;
        logic [SRC_W-1:0] en_val;
        logic             en_we;
    } bank_cmd_t;

    typedef struct packed {
        logic [SRC_W-1:0] pend;
        logic [SRC_W-1:0] en;
    } bank_state_t;

    function automatic reg_sel_e off_to_sel(input int unsigned off);
        case (off)
            OFF_PEND:  return SEL_PEND;
            OFF_EN:    return SEL_EN;
            OFF_GATED: return SEL_GATED;
            OFF_SET:   return SEL_SET;
            OFF_MASK:  return SEL_MASK;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic bank_cmd_t build_cmd(input reg_sel_e sel, input logic we,
                                            input logic [DATA_W-1:0] wdata);
        bank_cmd_t c;
        c = '0;
        if (we) begin
            case (sel)
                SEL_PEND: c.clr = wdata;
                SEL_SET:  c.set = wdata;
                SEL_EN: begin
                    c.en_val = wdata;
                    c.en_we  = 1'b1;
                end
                SEL_MASK: begin
                    c.en_val = ~wdata;
                    c.en_we  = 1'b1;
                end
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] read_view(input reg_sel_e sel,
                                                    input bank_state_t st);
        case (sel)
            SEL_PEND:  return st.pend;
            SEL_EN:    return st.en;
            SEL_GATED: return st.pend & st.en;
            SEL_MASK:  return ~st.en;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BASE   = 0,
    parameter int STRIDE = BANK_STRIDE
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W:0] BASE_A = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] SPAN_A = (ADDR_W+1)'(STRIDE);

    // An address below BASE wraps to a large relative value and so
    // falls outside the span, because the whole map fits in ADDR_W bits.
    logic [ADDR_W:0] rel;

    always_comb begin
        rel = {1'b0, addr} - BASE_A;
        if (rel < SPAN_A) sel = off_to_sel(32'(rel));
        else              sel = SEL_NONE;
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_W-1:0]  req,
    output logic [DATA_W-1:0] rdata,
    output logic [SRC_W-1:0]  gated,
    output logic              line_q
);
    bank_state_t st_q, st_d;
    bank_cmd_t   cmd;

    always_comb begin
        cmd  = build_cmd(sel, we, wdata);
        st_d = st_q;
        // a request or software set in the clearing cycle wins
        st_d.pend = (st_q.pend & ~cmd.clr) | req | cmd.set;
        if (cmd.en_we) st_d.en = cmd.en_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            line_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            line_q <= |gated;
        end
    end

    assign gated = st_q.pend & st_q.en;
    assign rdata = read_view(sel, st_q);
endmodule

// File: rtl/irqc_msb_enc.sv
module irqc_msb_enc #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8,
    parameter int LINE_BASE = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_BANKS*SRC_W-1:0] irq_req,
    output logic [NUM_BANKS+LINE_BASE-1:0] cpu_irq,
    output logic [NUM_BANKS*IDX_W-1:0] top_idx,
    output logic [NUM_BANKS-1:0]       top_valid
);
    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0] line_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        reg_sel_e         sel;
        logic [SRC_W-1:0] gated;

        irqc_addr_dec #(
            .ADDR_W (ADDR_W),
            .BASE   (b * BANK_STRIDE),
            .STRIDE (BANK_STRIDE)
        ) u_dec (
            .addr (bus_addr),
            .sel  (sel)
        );

        irqc_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .sel    (sel),
            .we     (bus_we),
            .wdata  (bus_wdata),
            .req    (irq_req[b*SRC_W +: SRC_W]),
            .rdata  (bank_rdata[b]),
            .gated  (gated),
            .line_q (line_q[b])
        );

        irqc_msb_enc #(
            .W     (SRC_W),
            .IDX_W (IDX_W)
        ) u_enc (
            .vec   (gated),
            .idx   (top_idx[b*IDX_W +: IDX_W]),
            .valid (top_valid[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) bus_rdata = bus_rdata | bank_rdata[b];
    end

    if (LINE_BASE > 0) begin : g_low_lines
        assign cpu_irq[LINE_BASE-1:0] = '0;
    end
    assign cpu_irq[NUM_BANKS+LINE_BASE-1:LINE_BASE] = line_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8,
    parameter int LINE_BASE = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_we,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_BANKS+LINE_BASE-1:0] cpu_irq,
    input logic [NUM_BANKS*IDX_W-1:0] top_idx,
    input logic [NUM_BANKS-1:0]       top_valid
);
    localparam int MAP_END = NUM_BANKS * BANK_STRIDE;

    // R1: reset leaves every line and flag low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (cpu_irq == '0 && top_valid == '0));

    // R7: addresses past the last bank read zero
    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(bus_addr) >= MAP_END) |-> (bus_rdata == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R8: line follows the bank's valid flag one cycle later
        assert_line_delay_R8: assert property (@(posedge clk) disable iff (rst)
            cpu_irq[b+LINE_BASE] == $past(top_valid[b]));

        // R9: an idle bank reports index zero
        assert_idle_idx_R9: assert property (@(posedge clk) disable iff (rst)
            !top_valid[b] |-> (top_idx[b*IDX_W +: IDX_W] == '0));

        // R6: the set register reads zero
        assert_set_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (32'(bus_addr) == b*BANK_STRIDE + OFF_SET) |-> (bus_rdata == '0));
    end
endmodule

bind irqc_top irqc_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .LINE_BASE (LINE_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .top_idx   (top_idx),
    .top_valid (top_valid)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
    localparam int NB = 5;
    localparam int STR = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [NB*32-1:0] irq_req = '0;
    logic [NB+1:0] cpu_irq;
    logic [NB*5-1:0] top_idx;
    logic [NB-1:0] top_valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pend [NB];
    logic [31:0] m_en   [NB];

    always #2.5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .cpu_irq(cpu_irq), .top_idx(top_idx), .top_valid(top_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] msb_of(input logic [31:0] v);
        logic [4:0] r = '0;
        for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int b, off;
        if (int'(a) >= NB*STR) return '0;
        b = int'(a) / STR;
        off = int'(a) % STR;
        case (off)
            0:  return m_pend[b];
            8:  return m_en[b];
            16: return m_pend[b] & m_en[b];
            32: return ~m_en[b];
            default: return '0;
        endcase
    endfunction

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [NB*32-1:0] r);
        logic [31:0] prev_g [NB];
        int ab, off;
        bus_we = we; bus_addr = a; bus_wdata = d; irq_req = r;
        @(posedge clk);
        ab = int'(a) / STR;
        off = int'(a) % STR;
        for (int b = 0; b < NB; b++) begin
            logic [31:0] clr, set;
            prev_g[b] = m_pend[b] & m_en[b];
            clr = '0; set = '0;
            if (we && int'(a) < NB*STR && ab == b) begin
                if (off == 0)  clr = d;
                if (off == 24) set = d;
                if (off == 8)  m_en[b] = d;
                if (off == 32) m_en[b] = ~d;
            end
            m_pend[b] = (m_pend[b] & ~clr) | r[b*32 +: 32] | set;
        end
        @(negedge clk);
        bus_we = 1'b0; irq_req = '0;
        chk(cpu_irq[1:0] == 2'b00, "R8 low lines", 32'(cpu_irq[1:0]), 32'd0);
        for (int b = 0; b < NB; b++) begin
            logic [31:0] g;
            g = m_pend[b] & m_en[b];
            chk(top_valid[b] == (g != 0), "R9 valid", 32'(top_valid[b]), 32'(g != 0));
            chk(top_idx[b*5 +: 5] == msb_of(g), "R9 index",
                32'(top_idx[b*5 +: 5]), 32'(msb_of(g)));
            chk(cpu_irq[b+2] == (prev_g[b] != 0), "R8 line",
                32'(cpu_irq[b+2]), 32'(prev_g[b] != 0));
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata == model_read(a), tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_all(input string tag);
        for (int b = 0; b < NB; b++)
            for (int o = 0; o <= 32; o += 8) rd(8'(b*STR + o), tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NB*32-1:0] r;
        void'($urandom(32'h5eed_1c00));
        for (int b = 0; b < NB; b++) begin m_pend[b] = '0; m_en[b] = '0; end
        irq_req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        irq_req = '0;
        // R1: reset state
        chk(cpu_irq == '0, "R1 lines", 32'(cpu_irq), 32'd0);
        chk(top_valid == '0, "R1 valid", 32'(top_valid), 32'd0);
        rd_all("R1 reset regs");

        // R2: pulse a request on bank 1 bit 5, it stays latched
        r = '0; r[32+5] = 1'b1;
        step(1'b0, 8'h00, 32'h0, r);
        step(1'b0, 8'h00, 32'h0, '0);
        rd(8'(STR + 0), "R2 latched pending");

        // R4: enable bank 1, index follows
        step(1'b1, 8'(STR + 8), 32'hFFFF_FFFF, '0);
        rd(8'(STR + 8), "R4 enable readback");
        rd(8'(STR + 32), "R4 mask inverse");
        step(1'b0, 8'h00, 32'h0, '0);

        // R3: clear while the request is still high keeps the bit
        step(1'b1, 8'(STR + 0), 32'h0000_0020, r);
        rd(8'(STR + 0), "R3 request wins over clear");
        step(1'b1, 8'(STR + 0), 32'h0000_0000, '0);
        rd(8'(STR + 0), "R3 zero write keeps");
        step(1'b1, 8'(STR + 0), 32'h0000_0020, '0);
        rd(8'(STR + 0), "R3 clear bit");

        // R6 and R4: bank 4 set via software, enable via mask view
        step(1'b1, 8'(4*STR + 24), 32'h8000_0001, '0);
        rd(8'(4*STR + 24), "R6 set reads zero");
        step(1'b1, 8'(4*STR + 32), 32'h0000_0000, '0);
        rd(8'(4*STR + 8), "R4 mask write");
        rd(8'(4*STR + 16), "R5 gated view");
        step(1'b1, 8'(4*STR + 32), 32'h8000_0000, '0);
        rd(8'(4*STR + 16), "R4 mask hides msb");

        // R5: writes to the view are ignored
        step(1'b1, 8'(4*STR + 16), 32'h0000_0000, '0);
        rd_all("R5 view write ignored");

        // R7: unmapped addresses
        step(1'b1, 8'h04, 32'hFFFF_FFFF, '0);
        step(1'b1, 8'hC8, 32'hFFFF_FFFF, '0);
        step(1'b1, 8'hFF, 32'hFFFF_FFFF, '0);
        rd(8'h04, "R7 gap read");
        rd(8'hC8, "R7 past end read");
        rd(8'hFF, "R7 top read");
        rd_all("R7 writes ignored");

        // R3: clear all ones
        step(1'b1, 8'(4*STR + 0), 32'hFFFF_FFFF, '0);
        rd(8'(4*STR + 0), "R3 clear all");

        // random traffic
        for (int it = 0; it < 3000; it++) begin
            int op, b;
            logic [7:0] a;
            op = int'($urandom % 8);
            b = int'($urandom % NB);
            r = '0;
            if ($urandom % 2 == 0)
                for (int k = 0; k < NB; k++) r[k*32 +: 32] = $urandom & $urandom & $urandom;
            case (op)
                0, 1: a = 8'(b*STR + 0);
                2:    a = 8'(b*STR + 8);
                3:    a = 8'(b*STR + 24);
                4:    a = 8'(b*STR + 32);
                5:    a = 8'(b*STR + 16);
                6:    a = 8'($urandom);
                default: a = 8'(b*STR + 4);
            endcase
            step(op != 7 || ($urandom % 2 == 0), a,
                 (op == 1) ? 32'hFFFF_FFFF : $urandom, r);
            rd(8'($urandom), "R7 random read");
            rd(8'(int'($urandom % NB)*STR + 8*int'($urandom % 5)), "R2 R4 R5 random read");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule